// File: doc/BRIEF.md
# Nibble-Mode Reverse Byte Receiver

This block pulls bytes from an IEEE 1284 peripheral over the reverse channel after the port has already been placed in nibble mode. The host side of the handshake is the nAutoFd line. The peripheral answers on nAck. Each byte arrives as two 4-bit halves on the four status inputs, the low half first. For every half the block runs a four-phase exchange. It pulls nAutoFd low to request data and waits for nAck to fall. It then samples the status inputs and raises nAutoFd to acknowledge. Finally it waits for nAck to rise again before it moves on.

A transfer starts with a one-cycle start pulse that carries a byte count. Completed bytes leave on a valid/ready stream that holds one entry. While that entry is unconsumed, no new byte is requested from the peripheral. Every wait on nAck is bounded by a count of timebase ticks. The wait for the first half of a byte uses a long idle limit. All other waits use a short response limit. When a transfer finishes, a single-cycle done pulse appears together with a result code and the number of bytes delivered. The handshake inputs are asynchronous and pass through a synchronizer before the control logic uses them.

Top module: `nibble_rx`

## Requirements
- R1: After reset, nAutoFd is high, the stream is empty, done is low, the result code is 0 and the delivered-byte count is 0.
- R2: nAutoFd is driven low only while a half-byte is being requested, and it stays high while the block is idle.
- R3: The first half of each byte forms bits 3..0 as {Busy, PError, Select, nFault}: nFault is bit 0, Select bit 1, PError bit 2, Busy bit 3. The Busy input is taken at its true level.
- R4: The second half forms bits 7..4 from the same four lines in the same order (nFault bit 4, Select bit 5, PError bit 6, Busy bit 7).
- R5: After nAutoFd rises to acknowledge a half, the block issues no new request until the synchronized nAck has returned high.
- R6: If nAck does not fall within IDLE_TICKS ticks of a first-half request, the transfer ends with result code 1. The request is held for exactly IDLE_TICKS ticks.
- R7: The nAck-low wait for the second half is bounded by RESP_TICKS ticks, not the idle limit. On expiry the transfer ends with result code 2, after exactly RESP_TICKS ticks of request.
- R8: If nAck does not return high within RESP_TICKS ticks after either acknowledgment, the transfer ends with result code 3.
- R9: A byte enters the stream only after both halves are captured. It is held unchanged with valid high until ready is seen, and the delivered-byte count rises by one per byte entered.
- R10: While a byte waits in the stream with ready low, nAutoFd does not fall for the next byte.
- R11: After the requested number of bytes completes, done pulses for exactly one cycle with nAutoFd high, result code 0 and a count equal to the request.
- R12: A start with a count of zero ends with done and result code 0, without ever lowering nAutoFd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase pulse used for all handshake time limits |
| start_i | input | 1 | One-cycle pulse that begins a transfer; ignored unless idle |
| len_i | input | LEN_W | Number of bytes to receive, sampled with start_i |
| nack_i | input | 1 | Peripheral strobe line (nAck), asynchronous |
| fault_n_i | input | 1 | nFault status line, asynchronous |
| select_i | input | 1 | Select status line, asynchronous |
| perror_i | input | 1 | PError status line, asynchronous |
| busy_i | input | 1 | Busy status at its true level, asynchronous |
| auto_fd_n_o | output | 1 | Host handshake line (nAutoFd), low requests a half-byte |
| byte_o | output | 8 | Received byte |
| byte_valid_o | output | 1 | Stream entry holds a byte |
| byte_ready_i | input | 1 | Downstream accepts the byte |
| done_o | output | 1 | One-cycle pulse at the end of a transfer |
| err_o | output | 2 | Result code: 0 ok, 1 idle timeout, 2 second-half timeout, 3 release timeout |
| count_o | output | LEN_W | Bytes delivered in the current or last transfer |

## Verification
The bound checker watches several properties on every cycle. nAutoFd never falls unless nAck had come back high, and it never falls while the stream still holds a byte. A stalled byte keeps its value. Each new byte raises the count by exactly one, and done only appears with nAutoFd released. Other behaviours can only be shown by the bench scenarios. These are the bit placement of every status line in both halves, swept over all 256 byte values. They also include the exact tick counts at which each of the three time limits fires, and the result code each limit produces. The last are the zero-length start and the way the done pulse lines up with the final count.

// File: rtl/nibble_rx_pkg.sv
package nibble_rx_pkg;

    // Controller phases; a request phase drives the host line low
    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_REQ_LO = 3'd1,
        S_REL_LO = 3'd2,
        S_REQ_HI = 3'd3,
        S_REL_HI = 3'd4,
        S_HOLD   = 3'd5
    } rx_state_e;

    // Result codes reported at the end of a transfer
    typedef enum logic [1:0] {
        RX_OK      = 2'd0,
        RX_IDLE_TO = 2'd1,
        RX_NIB_TO  = 2'd2,
        RX_REL_TO  = 2'd3
    } rx_err_e;

    // Peripheral-driven lines, kept together through the synchronizer
    typedef struct packed {
        logic ack_n;
        logic busy;
        logic perror;
        logic select;
        logic fault_n;
    } line_bundle_t;

    localparam int LINE_W = $bits(line_bundle_t);

    // Status lines to a half-byte: fault_n -> 0, select -> 1, perror -> 2, busy -> 3
    function automatic logic [3:0] lines_to_nibble(line_bundle_t l);
        return {l.busy, l.perror, l.select, l.fault_n};
    endfunction

    function automatic logic is_request(rx_state_e s);
        return (s == S_REQ_LO) || (s == S_REQ_HI);
    endfunction

    function automatic logic is_timed(rx_state_e s);
        return (s == S_REQ_LO) || (s == S_REL_LO) || (s == S_REQ_HI) || (s == S_REL_HI);
    endfunction

endpackage

// File: rtl/nibble_rx_sync.sv
module nibble_rx_sync #(
    parameter int             W       = 5,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= RST_VAL;
                    else     chain[g] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= RST_VAL;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];

endmodule

// File: rtl/nibble_rx_timer.sv
module nibble_rx_timer #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_i,
    input  logic          en_i,
    input  logic          tick_i,
    input  logic [CW-1:0] limit_i,
    output logic          expire_o
);

    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i)        cnt_q <= '0;
        else if (en_i && tick_i) cnt_q <= cnt_q + ONE;
    end

    // Fires on the tick that completes the limit
    assign expire_o = en_i && tick_i && ((cnt_q + ONE) == limit_i);

endmodule

// File: rtl/nibble_rx_ostage.sv
module nibble_rx_ostage #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_i,
    input  logic [DW-1:0] data_i,
    output logic          valid_o,
    input  logic          ready_i,
    output logic [DW-1:0] data_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            data_o  <= '0;
        end else if (push_i) begin
            valid_o <= 1'b1;
            data_o  <= data_i;
        end else if (ready_i) begin
            valid_o <= 1'b0;
        end
    end

endmodule

// File: rtl/nibble_rx.sv
module nibble_rx
    import nibble_rx_pkg::*;
#(
    parameter int IDLE_TICKS  = 2000,
    parameter int RESP_TICKS  = 6,
    parameter int LEN_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             nack_i,
    input  logic             fault_n_i,
    input  logic             select_i,
    input  logic             perror_i,
    input  logic             busy_i,
    output logic             auto_fd_n_o,
    output logic [7:0]       byte_o,
    output logic             byte_valid_o,
    input  logic             byte_ready_i,
    output logic             done_o,
    output logic [1:0]       err_o,
    output logic [LEN_W-1:0] count_o
);

    localparam int MAX_TICKS = (IDLE_TICKS > RESP_TICKS) ? IDLE_TICKS : RESP_TICKS;
    localparam int TW        = $clog2(MAX_TICKS + 1);
    localparam logic [TW-1:0]    IDLE_LIM = TW'(IDLE_TICKS);
    localparam logic [TW-1:0]    RESP_LIM = TW'(RESP_TICKS);
    localparam logic [LEN_W-1:0] LEN_ONE  = {{(LEN_W-1){1'b0}}, 1'b1};

    // ---------------- input synchronization ----------------
    line_bundle_t raw_l;
    line_bundle_t sync_l;
    logic         ack_s;

    assign raw_l.ack_n   = nack_i;
    assign raw_l.busy    = busy_i;
    assign raw_l.perror  = perror_i;
    assign raw_l.select  = select_i;
    assign raw_l.fault_n = fault_n_i;

    nibble_rx_sync #(
        .W       (LINE_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({LINE_W{1'b1}})
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_l),
        .q_o (sync_l)
    );

    assign ack_s = sync_l.ack_n;

    // ---------------- state ----------------
    rx_state_e        state_q, state_nx;
    logic [3:0]       lo_nib_q;
    logic [LEN_W-1:0] req_len_q;
    logic [LEN_W-1:0] xfer_q;
    rx_err_e          err_q;
    logic             done_q;

    logic             load, cap_lo, push, finish;
    rx_err_e          fin_err;
    logic             tmr_exp, tmr_clr, tmr_en;
    logic [TW-1:0]    tmr_limit;
    logic             last_byte;
    logic [7:0]       byte_assembled;

    assign last_byte      = (xfer_q == req_len_q);
    assign byte_assembled = {lines_to_nibble(sync_l), lo_nib_q};

    // ---------------- handshake timer ----------------
    assign tmr_en    = is_timed(state_q);
    assign tmr_clr   = (state_nx != state_q);
    assign tmr_limit = (state_q == S_REQ_LO) ? IDLE_LIM : RESP_LIM;

    nibble_rx_timer #(
        .CW (TW)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (tmr_clr),
        .en_i     (tmr_en),
        .tick_i   (tick),
        .limit_i  (tmr_limit),
        .expire_o (tmr_exp)
    );

    // ---------------- control ----------------
    always_comb begin
        state_nx = state_q;
        load     = 1'b0;
        cap_lo   = 1'b0;
        push     = 1'b0;
        finish   = 1'b0;
        fin_err  = RX_OK;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) begin
                    load = 1'b1;
                    if (len_i == '0) finish   = 1'b1;
                    else             state_nx = S_REQ_LO;
                end
            end
            S_REQ_LO: begin
                if (!ack_s) begin
                    cap_lo   = 1'b1;
                    state_nx = S_REL_LO;
                end else if (tmr_exp) begin
                    finish   = 1'b1;
                    fin_err  = RX_IDLE_TO;
                    state_nx = S_IDLE;
                end
            end
            S_REL_LO: begin
                if (ack_s) begin
                    state_nx = S_REQ_HI;
                end else if (tmr_exp) begin
                    finish   = 1'b1;
                    fin_err  = RX_REL_TO;
                    state_nx = S_IDLE;
                end
            end
            S_REQ_HI: begin
                if (!ack_s) begin
                    push     = 1'b1;
                    state_nx = S_REL_HI;
                end else if (tmr_exp) begin
                    finish   = 1'b1;
                    fin_err  = RX_NIB_TO;
                    state_nx = S_IDLE;
                end
            end
            S_REL_HI: begin
                if (ack_s) begin
                    if (last_byte) begin
                        finish   = 1'b1;
                        state_nx = S_IDLE;
                    end else begin
                        state_nx = S_HOLD;
                    end
                end else if (tmr_exp) begin
                    finish   = 1'b1;
                    fin_err  = RX_REL_TO;
                    state_nx = S_IDLE;
                end
            end
            S_HOLD: begin
                if (!byte_valid_o) state_nx = S_REQ_LO;
            end
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= S_IDLE;
            lo_nib_q  <= '0;
            req_len_q <= '0;
            xfer_q    <= '0;
            err_q     <= RX_OK;
            done_q    <= 1'b0;
        end else begin
            state_q <= state_nx;
            done_q  <= finish;
            if (load) begin
                req_len_q <= len_i;
                xfer_q    <= '0;
                err_q     <= RX_OK;
            end
            if (cap_lo) lo_nib_q <= lines_to_nibble(sync_l);
            if (push)   xfer_q   <= xfer_q + LEN_ONE;
            if (finish) err_q    <= fin_err;
        end
    end

    // ---------------- output stream ----------------
    nibble_rx_ostage #(
        .DW (8)
    ) u_ostage (
        .clk     (clk),
        .rst     (rst),
        .push_i  (push),
        .data_i  (byte_assembled),
        .valid_o (byte_valid_o),
        .ready_i (byte_ready_i),
        .data_o  (byte_o)
    );

    assign auto_fd_n_o = !is_request(state_q);
    assign done_o      = done_q;
    assign err_o       = err_q;
    assign count_o     = xfer_q;

endmodule

// File: rtl/nibble_rx_chk.sv
module nibble_rx_chk #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             auto_fd_n,
    input logic             ack_s,
    input logic             out_valid,
    input logic             out_ready,
    input logic [7:0]       out_data,
    input logic             done,
    input logic [LEN_W-1:0] count
);

    // R5
    req_after_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(auto_fd_n) |-> $past(ack_s));

    // R10
    no_req_while_full_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(auto_fd_n) |-> !$past(out_valid));

    // R9
    stalled_byte_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R9
    count_per_byte_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> (count == $past(count) + 1'b1));

    // R11
    done_released_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> auto_fd_n);

endmodule

bind nibble_rx nibble_rx_chk #(.LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .auto_fd_n (auto_fd_n_o),
    .ack_s     (ack_s),
    .out_valid (byte_valid_o),
    .out_ready (byte_ready_i),
    .out_data  (byte_o),
    .done      (done_o),
    .count     (count_o)
);

// File: tb/nibble_rx_tb_top.sv
`timescale 1ns/1ps
module nibble_rx_tb_top;

    localparam int IDLE_T = 2000;
    localparam int RESP_T = 6;
    localparam int LW     = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick = 1'b0;
    logic          start_i = 1'b0;
    logic [LW-1:0] len_i = '0;
    logic          nack_i = 1'b1;
    logic          fault_n_i = 1'b1;
    logic          select_i = 1'b0;
    logic          perror_i = 1'b0;
    logic          busy_i = 1'b0;
    logic          rdy = 1'b1;
    logic          auto_fd_n_o;
    logic [7:0]    byte_o;
    logic          byte_valid_o;
    logic          done_o;
    logic [1:0]    err_o;
    logic [LW-1:0] count_o;

    always #2.5 clk = ~clk;

    nibble_rx #(
        .IDLE_TICKS  (IDLE_T),
        .RESP_TICKS  (RESP_T),
        .LEN_W       (LW),
        .SYNC_STAGES (2)
    ) dut_i (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick),
        .start_i      (start_i),
        .len_i        (len_i),
        .nack_i       (nack_i),
        .fault_n_i    (fault_n_i),
        .select_i     (select_i),
        .perror_i     (perror_i),
        .busy_i       (busy_i),
        .auto_fd_n_o  (auto_fd_n_o),
        .byte_o       (byte_o),
        .byte_valid_o (byte_valid_o),
        .byte_ready_i (rdy),
        .done_o       (done_o),
        .err_o        (err_o),
        .count_o      (count_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    int exp_mem [0:599];
    int wr_idx = 0;
    int rd_idx = 0;
    int tick_lo = 0;
    int early_req = 0;
    bit finished = 0;

    task automatic chk_eq(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic end_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // timebase: high every other cycle, changed just after the rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1 tick = ~tick;
        end
    end

    // ticks spent with a request outstanding
    always @(negedge clk) begin
        if (!rst && !auto_fd_n_o && tick) tick_lo++;
    end

    // stream sink: R3 R4 values checked against the bytes the peripheral sent
    always @(negedge clk) begin
        if (!rst && byte_valid_o && rdy) begin
            chk_eq("R3 R4 byte value", int'(byte_o), exp_mem[rd_idx]);
            rd_idx++;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        end_run();
    end

    task automatic set_ready(input logic v);
        @(posedge clk);
        #1 rdy = v;
    endtask

    task automatic start_xfer(input int n);
        @(negedge clk);
        start_i = 1'b1;
        len_i   = LW'(n);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // peripheral side of one half-byte; hold = cycles nAck stays low after release
    task automatic p_nibble(input logic [3:0] n, input int hold);
        while (auto_fd_n_o) @(negedge clk);
        {busy_i, perror_i, select_i, fault_n_i} = n;
        @(negedge clk);
        nack_i = 1'b0;
        while (!auto_fd_n_o) @(negedge clk);
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            if (!auto_fd_n_o) early_req++;
        end
        nack_i = 1'b1;
    endtask

    task automatic p_byte(input int v, input int hold);
        exp_mem[wr_idx] = v;
        wr_idx++;
        p_nibble(v[3:0], hold);
        p_nibble(v[7:4], hold);
    endtask

    task automatic wait_done();
        while (!done_o) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk_eq("R1 nAutoFd after reset", int'(auto_fd_n_o), 1);
        chk_eq("R1 valid after reset", int'(byte_valid_o), 0);
        chk_eq("R1 done after reset", int'(done_o), 0);
        chk_eq("R1 code after reset", int'(err_o), 0);
        chk_eq("R1 count after reset", int'(count_o), 0);

        // R2 idle keeps host line high
        begin
            int lows = 0;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (!auto_fd_n_o) lows++;
            end
            chk_eq("R2 host line high while idle", lows, 0);
        end

        // R3 R4 sweep over every byte value
        start_xfer(256);
        for (int v = 0; v < 256; v++) p_byte(v, 1);
        wait_done();
        chk_eq("R11 count at done", int'(count_o), 256);
        chk_eq("R11 code at done", int'(err_o), 0);
        chk_eq("R11 host line at done", int'(auto_fd_n_o), 1);
        @(negedge clk);
        chk_eq("R11 done is one cycle", int'(done_o), 0);
        chk_eq("R9 bytes received in sweep", rd_idx, 256);

        // R5 slow release: no new request while nAck is low
        start_xfer(2);
        p_byte(8'hC3, 6);
        p_byte(8'h3C, 6);
        wait_done();
        chk_eq("R5 requests while nAck low", early_req, 0);
        chk_eq("R5 count after slow release", int'(count_o), 2);

        // R10 R9 stall with ready low
        set_ready(1'b0);
        start_xfer(2);
        p_byte(8'h5A, 1);
        while (!byte_valid_o) @(negedge clk);
        begin
            int lows = 0;
            int changed = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (!auto_fd_n_o) lows++;
                if (byte_o != 8'h5A || !byte_valid_o) changed++;
            end
            chk_eq("R10 request while stream full", lows, 0);
            chk_eq("R9 stalled byte held", changed, 0);
            chk_eq("R9 count with one byte pending", int'(count_o), 1);
        end
        set_ready(1'b1);
        p_byte(8'hA5, 1);
        wait_done();
        chk_eq("R11 count after stall", int'(count_o), 2);
        repeat (3) @(negedge clk);
        chk_eq("R9 bytes received after stall", rd_idx, 260);

        // R6 idle timeout on the first half
        tick_lo = 0;
        start_xfer(1);
        begin
            int seen = 0;
            for (int i = 0; i < 5; i++) begin
                if (!auto_fd_n_o) seen = 1;
                @(negedge clk);
            end
            chk_eq("R2 host line low for request", seen, 1);
        end
        wait_done();
        chk_eq("R6 idle timeout code", int'(err_o), 1);
        chk_eq("R6 ticks before idle timeout", tick_lo, IDLE_T);
        chk_eq("R6 count after idle timeout", int'(count_o), 0);

        // R7 second half times out on the short limit
        start_xfer(1);
        p_nibble(4'h9, 1);
        tick_lo = 0;
        wait_done();
        chk_eq("R7 second half timeout code", int'(err_o), 2);
        chk_eq("R7 ticks before second half timeout", tick_lo, RESP_T);
        chk_eq("R9 no byte from a single half", int'(count_o), 0);
        repeat (3) @(negedge clk);
        chk_eq("R9 nothing on stream after half byte", rd_idx, 260);

        // R8 nAck never released after the first half
        start_xfer(1);
        while (auto_fd_n_o) @(negedge clk);
        @(negedge clk);
        nack_i = 1'b0;
        wait_done();
        chk_eq("R8 release timeout code", int'(err_o), 3);
        nack_i = 1'b1;
        repeat (10) @(negedge clk);

        // R12 zero length
        begin
            int lows = 0;
            int got = 0;
            start_xfer(0);
            for (int i = 0; i < 10; i++) begin
                if (!auto_fd_n_o) lows++;
                if (done_o) got++;
                @(negedge clk);
            end
            chk_eq("R12 host line during zero length", lows, 0);
            chk_eq("R12 done for zero length", got, 1);
            chk_eq("R12 code for zero length", int'(err_o), 0);
            chk_eq("R12 count for zero length", int'(count_o), 0);
        end

        end_run();
    end

endmodule